// File: doc/BRIEF.md
# Type B Card-Side Frame Serializer

This block turns a stream of octets into the framed, line-coded bit sequence that a proximity card sends back to a reader over a Type B contactless link. Each frame has four parts, in this order:

- a run of logic ones that lets the reader settle its phase reference;
- a start-of-frame pattern;
- one 10-bit character per octet;
- an end-of-frame pattern.

The caller appends the check bytes before handing the octets over. The block treats them as ordinary data and computes nothing itself.

Octets arrive on a valid/ready handshake, with a marker for the first octet and a marker for the last. The output advances by exactly one symbol on each pulse of an external etu strobe. Subcarrier modulation happens downstream. A busy flag covers the whole frame, and a one-cycle done pulse closes it. Between characters the block requests the next octet only after the stop bit and one extra high etu have gone out.

Top module: `typeb_frame_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, `tx_bit` is 1, `tx_busy` is 0, `tx_done` is 0 and `in_ready` is 1.
- R2: A frame starts only when a beat is accepted with `in_first`=1. A beat accepted while idle with `in_first`=0 is consumed and has no effect: there is no busy and no done, and the line stays high.
- R3: The frame opens with 20 consecutive etus of logic 1.
- R4: The start-of-frame pattern follows at once: 10 etus of 0, then 2 etus of 1.
- R5: Each octet goes out as a 10-bit character. The character is a start bit 0, then the 8 data bits least significant first, then a stop bit 1. Octets are sent verbatim, including any check bytes.
- R6: After the stop bit of a character that is not the last, the line stays 1 for one more etu. Only then is `in_ready` raised for the next octet. While `in_ready` is high during a frame, the line is 1.
- R7: After the stop bit of the octet that carried `in_last`=1, the end-of-frame pattern follows at once: 10 etus of 0, then 2 etus of 1.
- R8: `tx_bit` changes only in the clock cycle after an `etu_tick` pulse, and each pulse advances the frame by one symbol.
- R9: `tx_busy` rises when the first octet is accepted. One etu after the last end-of-frame bit, `tx_done` pulses for exactly one cycle and `tx_busy` falls in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| etu_tick | input | 1 | One-cycle strobe, one per elementary time unit |
| in_valid | input | 1 | Octet on `in_data` is offered |
| in_ready | output | 1 | Block accepts the offered octet this cycle |
| in_data | input | 8 | Octet to send |
| in_first | input | 1 | Marks the first octet of a frame |
| in_last | input | 1 | Marks the final octet of a frame |
| tx_bit | output | 1 | Line-coded serial output, registered |
| tx_busy | output | 1 | High while a frame is being sent |
| tx_done | output | 1 | One-cycle pulse at frame end |

## Verification
Every symbol is due in the cycle right after the `etu_tick` edge that launches it, because one register sits between the sequencer and `tx_bit`. The done pulse and the fall of busy come in the cycle after the tick that ends the last end-of-frame etu.

The bench builds the expected symbol list per frame before driving it. A monitor records, at each rising edge, whether a tick fell while a frame was in progress, and compares one symbol at the following falling edge. A tick on the edge that accepts the first octet is excluded, since busy was still low before that edge. The bench also checks that no level change ever appears without a tick on the preceding edge, and it runs one frame with a slower strobe.

// File: rtl/typeb_tx_pkg.sv
package typeb_tx_pkg;
  typedef enum logic [3:0] {
    PH_IDLE,
    PH_LEAD,
    PH_SOF_LO,
    PH_SOF_HI,
    PH_CHAR,
    PH_GUARD,
    PH_FETCH,
    PH_EOF_LO,
    PH_EOF_HI,
    PH_CLOSE
  } phase_t;
endpackage

// File: rtl/typeb_char_ser.sv
module typeb_char_ser #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  input  logic              shift,
  output logic              cur_bit
);
  localparam int CHAR_W = DATA_W + 2;

  logic [CHAR_W-1:0] sh;

  // stop bit in the top position, start bit in the bottom one; shifts right
  always_ff @(posedge clk) begin
    if (rst) begin
      sh <= '1;
    end else if (load) begin
      sh <= {1'b1, din, 1'b0};
    end else if (shift) begin
      sh <= {1'b1, sh[CHAR_W-1:1]};
    end
  end

  assign cur_bit = sh[0];

  p_start_low_r5: assert property (@(posedge clk) disable iff (rst)
    load |=> (cur_bit == 1'b0));
endmodule

// File: rtl/typeb_seq.sv
module typeb_seq
  import typeb_tx_pkg::*;
#(
  parameter int LEAD_LEN   = 20,
  parameter int SOF_LO_LEN = 10,
  parameter int SOF_HI_LEN = 2,
  parameter int EOF_LO_LEN = 10,
  parameter int EOF_HI_LEN = 2,
  parameter int CHAR_BITS  = 10
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   tick,
  input  logic   in_valid,
  input  logic   in_first,
  input  logic   in_last,
  output phase_t phase,
  output logic   in_ready,
  output logic   load,
  output logic   shift,
  output logic   busy,
  output logic   done
);
  localparam int M1    = (LEAD_LEN > SOF_LO_LEN) ? LEAD_LEN : SOF_LO_LEN;
  localparam int M2    = (M1 > EOF_LO_LEN) ? M1 : EOF_LO_LEN;
  localparam int M3    = (M2 > CHAR_BITS) ? M2 : CHAR_BITS;
  localparam int M4    = (M3 > SOF_HI_LEN) ? M3 : SOF_HI_LEN;
  localparam int M5    = (M4 > EOF_HI_LEN) ? M4 : EOF_HI_LEN;
  localparam int CNT_W = $clog2(M5 + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] end_cnt;
  logic             last_q;
  phase_t           nxt;

  always_comb begin
    end_cnt = '0;
    nxt     = PH_IDLE;
    case (phase)
      PH_LEAD:   begin end_cnt = CNT_W'(LEAD_LEN - 1);   nxt = PH_SOF_LO; end
      PH_SOF_LO: begin end_cnt = CNT_W'(SOF_LO_LEN - 1); nxt = PH_SOF_HI; end
      PH_SOF_HI: begin end_cnt = CNT_W'(SOF_HI_LEN - 1); nxt = PH_CHAR;   end
      PH_CHAR:   begin end_cnt = CNT_W'(CHAR_BITS - 1);  nxt = last_q ? PH_EOF_LO : PH_GUARD; end
      PH_GUARD:  begin end_cnt = '0;                     nxt = PH_FETCH;  end
      PH_EOF_LO: begin end_cnt = CNT_W'(EOF_LO_LEN - 1); nxt = PH_EOF_HI; end
      PH_EOF_HI: begin end_cnt = CNT_W'(EOF_HI_LEN - 1); nxt = PH_CLOSE;  end
      PH_CLOSE:  begin end_cnt = '0;                     nxt = PH_IDLE;   end
      default:   begin end_cnt = '0;                     nxt = phase;     end
    endcase
  end

  assign in_ready = (phase == PH_IDLE) || (phase == PH_FETCH);
  assign load     = in_valid && (((phase == PH_IDLE) && in_first) || (phase == PH_FETCH));
  assign shift    = tick && (phase == PH_CHAR);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= PH_IDLE;
      cnt    <= '0;
      last_q <= 1'b0;
      busy   <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (phase)
        PH_IDLE: begin
          if (in_valid && in_first) begin
            phase  <= PH_LEAD;
            cnt    <= '0;
            last_q <= in_last;
            busy   <= 1'b1;
          end
        end
        PH_FETCH: begin
          if (in_valid) begin
            phase  <= PH_CHAR;
            cnt    <= '0;
            last_q <= in_last;
          end
        end
        default: begin
          if (tick) begin
            if (cnt == end_cnt) begin
              cnt   <= '0;
              phase <= nxt;
              if (phase == PH_CLOSE) begin
                busy <= 1'b0;
                done <= 1'b1;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
      endcase
    end
  end

  p_fetch_after_guard_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(phase == PH_FETCH) |-> ($past(phase) == PH_GUARD));
endmodule

// File: rtl/typeb_frame_tx.sv
module typeb_frame_tx
  import typeb_tx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int LEAD_LEN   = 20,
  parameter int SOF_LO_LEN = 10,
  parameter int SOF_HI_LEN = 2,
  parameter int EOF_LO_LEN = 10,
  parameter int EOF_HI_LEN = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              etu_tick,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_first,
  input  logic              in_last,
  output logic              tx_bit,
  output logic              tx_busy,
  output logic              tx_done
);
  localparam int CHAR_BITS = DATA_W + 2;

  phase_t phase;
  logic   load, shift, ser_bit, sym;

  typeb_seq #(
    .LEAD_LEN  (LEAD_LEN),
    .SOF_LO_LEN(SOF_LO_LEN),
    .SOF_HI_LEN(SOF_HI_LEN),
    .EOF_LO_LEN(EOF_LO_LEN),
    .EOF_HI_LEN(EOF_HI_LEN),
    .CHAR_BITS (CHAR_BITS)
  ) u_seq (
    .clk     (clk),
    .rst     (rst),
    .tick    (etu_tick),
    .in_valid(in_valid),
    .in_first(in_first),
    .in_last (in_last),
    .phase   (phase),
    .in_ready(in_ready),
    .load    (load),
    .shift   (shift),
    .busy    (tx_busy),
    .done    (tx_done)
  );

  typeb_char_ser #(.DATA_W(DATA_W)) u_ser (
    .clk    (clk),
    .rst    (rst),
    .load   (load),
    .din    (in_data),
    .shift  (shift),
    .cur_bit(ser_bit)
  );

  always_comb begin
    case (phase)
      PH_SOF_LO, PH_EOF_LO: sym = 1'b0;
      PH_CHAR:              sym = ser_bit;
      default:              sym = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)           tx_bit <= 1'b1;
    else if (etu_tick) tx_bit <= sym;
  end

  p_idle_high_r1: assert property (@(posedge clk) disable iff (rst)
    !tx_busy |-> tx_bit);
  p_hold_between_ticks_r8: assert property (@(posedge clk) disable iff (rst)
    !$past(etu_tick) |-> $stable(tx_bit));
  p_wait_line_high_r6: assert property (@(posedge clk) disable iff (rst)
    (in_ready && tx_busy) |-> tx_bit);
  p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
    tx_done |=> !tx_done);
  p_done_ends_busy_r9: assert property (@(posedge clk) disable iff (rst)
    tx_done |-> (!tx_busy && $past(tx_busy)));
endmodule

// File: tb/sim_typeb_frame_tx.sv
module sim_typeb_frame_tx;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       etu_tick = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = 8'h00;
  logic       in_first = 1'b0;
  logic       in_last = 1'b0;
  logic       tx_bit, tx_busy, tx_done;

  typedef struct {
    logic  b;
    string tag;
  } exp_t;

  exp_t  q[$];
  int    total = 0;
  int    bad = 0;
  int    tick_div = 4;
  int    div_cnt = 0;
  int    dones = 0;
  int    untimed = 0;
  bit    mon_on = 0;
  bit    finished = 0;
  logic  tick_busy_q = 0, tick_any_q = 0, acc_q = 0, prev_bit = 1;
  string last_tag = "";

  typeb_frame_tx u0 (
    .clk(clk), .rst(rst), .etu_tick(etu_tick),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_first(in_first), .in_last(in_last),
    .tx_bit(tx_bit), .tx_busy(tx_busy), .tx_done(tx_done)
  );

  always #4 clk = ~clk;

  // etu strobe, changed away from the rising edge
  always @(negedge clk) begin
    if (div_cnt >= tick_div - 1) begin
      div_cnt  <= 0;
      etu_tick <= 1'b1;
    end else begin
      div_cnt  <= div_cnt + 1;
      etu_tick <= 1'b0;
    end
  end

  always @(posedge clk) begin
    tick_busy_q <= etu_tick && tx_busy;
    tick_any_q  <= etu_tick;
    acc_q       <= in_valid && in_ready && tx_busy;
    if (tx_done) dones <= dones + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // monitor: one symbol per busy tick, compared in the cycle after the edge
  always @(negedge clk) begin
    if (mon_on) begin
      if (tx_bit !== prev_bit && !tick_any_q) untimed++;   // R8
      prev_bit = tx_bit;
      if (acc_q) check(last_tag == "R6", "R6 fetch before guard etu", 0, 1);
      if (tick_busy_q) begin
        if (q.size() == 0) begin
          check(0, "R9 symbol after frame end", int'(tx_bit), 1);
        end else begin
          exp_t e;
          e = q.pop_front();
          last_tag = e.tag;
          check(tx_bit === e.b, e.tag, int'(tx_bit), int'(e.b));
          if (q.size() == 0)
            check(tx_done === 1'b1 && tx_busy === 1'b0, "R9 done with busy low",
                  int'({tx_done, tx_busy}), 2);
        end
      end
    end
  end

  task automatic push(input logic b, input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      exp_t e;
      e.b = b;
      e.tag = tag;
      q.push_back(e);
    end
  endtask

  task automatic expect_frame(input logic [7:0] bytes[$]);
    push(1'b1, 20, "R3");
    push(1'b0, 10, "R4");
    push(1'b1, 2, "R4");
    for (int k = 0; k < bytes.size(); k++) begin
      push(1'b0, 1, "R5");
      for (int j = 0; j < 8; j++) push(bytes[k][j], 1, "R5");
      push(1'b1, 1, "R5");
      if (k != bytes.size() - 1) push(1'b1, 1, "R6");
    end
    push(1'b0, 10, "R7");
    push(1'b1, 2, "R7");
    push(1'b1, 1, "R9");
  endtask

  task automatic put_byte(input logic [7:0] b, input logic f, input logic l);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    in_first = f;
    in_last  = l;
    @(negedge clk);
    in_valid = 1'b0;
    in_first = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic run_frame(input logic [7:0] bytes[$]);
    int d0;
    d0 = dones;
    expect_frame(bytes);
    for (int k = 0; k < bytes.size(); k++)
      put_byte(bytes[k], k == 0, k == bytes.size() - 1);
    while (q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    check(dones == d0 + 1, "R9 one done per frame", dones - d0, 1);
    check(tx_bit === 1'b1 && tx_busy === 1'b0 && in_ready === 1'b1, "R1 idle after frame",
          int'({tx_bit, tx_busy, in_ready}), 5);
  endtask

  initial begin
    logic [7:0] f1[$];
    logic [7:0] f2[$];
    logic [7:0] f3[$];
    int d0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    prev_bit = tx_bit;
    mon_on = 1;
    check(tx_bit === 1'b1 && tx_busy === 1'b0 && tx_done === 1'b0 && in_ready === 1'b1,
          "R1 reset state", int'({tx_bit, tx_busy, tx_done, in_ready}), 9);

    // R2: beat without first marker while idle is dropped
    d0 = dones;
    put_byte(8'h55, 1'b0, 1'b1);
    repeat (60) @(negedge clk);
    check(tx_busy === 1'b0 && tx_bit === 1'b1, "R2 stray beat ignored",
          int'({tx_busy, tx_bit}), 1);
    check(dones == d0, "R2 no done from stray beat", dones - d0, 0);

    f1 = '{8'hA5};
    run_frame(f1);
    f2 = '{8'h00, 8'hFF, 8'h3C};
    run_frame(f2);
    tick_div = 7;
    f3 = '{8'h50, 8'h21, 8'hD7, 8'h81};
    run_frame(f3);
    tick_div = 4;

    check(untimed == 0, "R8 changes only after a tick", untimed, 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule